// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Register Bank

This block holds a 32-bit pending word for each of up to sixteen processors. Software reaches a processor's word through a 4 KB address page chosen by that processor's index. Inside the page, one word reads the pending bits, one word sets bits when a one is written and one word clears bits when a one is written. Software can change only the upper fifteen bits, 31 down to 17. These are the soft-interrupt bits.

A hardware level port also writes to the same words. It names a processor and a priority level from 1 to 15, and sets or clears that level's bit as the source asserts or drops. From the soft bits of each word, the block finds the highest pending soft level for that processor. It gives this level on a registered 4-bit output, one output per processor. The master source mapping sits outside this block, and it drives the hardware level port.

Top module: `cpu_softirq_bank`

## Requirements
- R1: The processor index is `bus_addr[15:12]` and the word select is `bus_addr[3:2]`. No other address bit changes which word is reached or what happens.
- R2: Reading word 0 returns the addressed processor's pending word. Reading word 1, 2 or 3 returns 0.
- R3: Writing word 2 sets each pending bit in 31:17 where the write data holds a one. Data bits 16:0 have no effect.
- R4: Writing word 1 clears each pending bit in 31:17 where the write data holds a one. Data bits 16:0 have no effect, so bits set by hardware survive a clear of all ones.
- R5: Writing word 3 changes no pending bit of any processor.
- R6: When `hw_valid` is high and `hw_level` L is nonzero, bit L of processor `hw_cpu`'s word is set if `hw_on` is 1 and cleared if `hw_on` is 0. When L is 0 nothing changes.
- R7: A processor's soft level is j-16, where j is the highest set bit in 17..31 of its word. The level is 0 when none of those bits is set. Hardware bits 1..15 do not add to the level.
- R8: A processor's soft level output changes on the clock edge after the edge that updated its pending word.
- R9: If a hardware update and a software write reach the same processor in the same cycle, both take effect. On a bit that is both set and cleared, the clear wins.
- R10: A synchronous active-low reset clears every pending word and every soft level output to 0.
- R11: A write or hardware update aimed at one processor leaves every other processor's word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the bus access |
| bus_addr | input | 16 | Byte address; the page selects the processor and bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| hw_valid | input | 1 | Hardware level update strobe |
| hw_on | input | 1 | 1 sets the level bit, 0 clears it |
| hw_cpu | input | 4 | Target processor of the hardware update |
| hw_level | input | 4 | Level bit to update; 0 means no update |
| soft_level | output | 64 | Registered soft level, 4 bits per processor, processor n at bits 4n+3:4n |

## Verification
The assertions assume three things about the inputs. The bus and the hardware port each make at most one request per cycle. A software set and a software clear never land in the same cycle, since there is only one bus. Hardware levels stay below bit 17, so a hardware update never touches the soft bits. The bench drives the bus and the hardware port only at falling edges, with one request per strobe. It overlaps the two ports in just one deliberate case, so every stimulus stays inside these limits. It sweeps every processor page and every soft bit position, and it computes the expected words and levels by arithmetic.

// File: rtl/softirq_pkg.sv
// Package: shared word-select encoding for the soft interrupt bank.
// Assumes a 2-bit word field taken from byte address bits 3:2.
package softirq_pkg;

    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned WORD_W   = 2;

    typedef enum logic [WORD_W-1:0] {
        WSEL_PEND  = 2'd0,
        WSEL_CLEAR = 2'd1,
        WSEL_SET   = 2'd2,
        WSEL_SPARE = 2'd3
    } word_sel_e;

endpackage

// File: rtl/sirq_addr_decode.sv
// Address decoder: splits the bus address into a processor page and a
// word select, and produces per-processor set, clear and read selects.
// Assumes the processor index field starts at PAGE_LSB.
module sirq_addr_decode
    import softirq_pkg::*;
#(
    parameter int unsigned NUM_CPU  = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PAGE_LSB = 12,
    localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [NUM_CPU-1:0] set_sel,
    output logic [NUM_CPU-1:0] clr_sel,
    output logic [NUM_CPU-1:0] rd_sel
);

    logic [CPU_W-1:0] cpu_idx;
    word_sel_e        word;
    logic             unused_addr_bits;

    // Pull the page index and word field out of the address.
    always_comb begin
        cpu_idx = bus_addr[PAGE_LSB +: CPU_W];
        word    = word_sel_e'(bus_addr[WORD_LSB +: WORD_W]);
    end

    assign unused_addr_bits = ^bus_addr;

    // One select line per processor page.
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_sel
        logic page_hit;
        assign page_hit   = (cpu_idx == CPU_W'(i));
        assign set_sel[i] = bus_wr && page_hit && (word == WSEL_SET);
        assign clr_sel[i] = bus_wr && page_hit && (word == WSEL_CLEAR);
        assign rd_sel[i]  = page_hit && (word == WSEL_PEND);
    end

    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_sel, clr_sel}));

endmodule

// File: rtl/sirq_pend_reg.sv
// One processor's pending word. Software set and clear are limited to
// the soft field. Hardware masks arrive already decoded. Clear beats set.
// Assumes software set and clear never arrive in the same cycle.
module sirq_pend_reg #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SOFT_LO = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic [DATA_W-1:0] sw_data,
    input  logic [DATA_W-1:0] hw_set_mask,
    input  logic [DATA_W-1:0] hw_clr_mask,
    output logic [DATA_W-1:0] pend
);

    localparam logic [DATA_W-1:0] SOFT_MASK =
        {{(DATA_W-SOFT_LO){1'b1}}, {SOFT_LO{1'b0}}};

    logic [DATA_W-1:0] sw_bits;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] pend_d;

    // Merge software and hardware requests; clears applied last.
    always_comb begin
        sw_bits = sw_data & SOFT_MASK;
        set_vec = (sw_set ? sw_bits : '0) | hw_set_mask;
        clr_vec = (sw_clr ? sw_bits : '0) | hw_clr_mask;
        pend_d  = (pend | set_vec) & ~clr_vec;
    end

    // Pending state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_d;
    end

    // R3
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set && !sw_clr) |=>
        ((pend & $past(sw_data & SOFT_MASK)) == $past(sw_data & SOFT_MASK)));

    // R4
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> ((pend & $past(sw_data & SOFT_MASK)) == '0));

    // R4
    low_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_set || sw_clr) && hw_set_mask == '0 && hw_clr_mask == '0) |=>
        (pend[SOFT_LO-1:0] == $past(pend[SOFT_LO-1:0])));

    // R6
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_mask != '0) |=>
        ((pend & $past(hw_set_mask)) == $past(hw_set_mask)));

    // R6
    hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_mask != '0) |=> ((pend & $past(hw_clr_mask)) == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0));

endmodule

// File: rtl/sirq_level_enc.sv
// Priority encoder for one processor: finds the highest set soft bit
// and registers its level (bit offset plus one); 0 when none is set.
// Assumes LVL_W is wide enough to hold SOFT_W.
module sirq_level_enc #(
    parameter int unsigned SOFT_W = 15,
    parameter int unsigned LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SOFT_W-1:0] soft_bits,
    output logic [LVL_W-1:0]  level
);

    logic [LVL_W-1:0] level_d;

    // Ascending scan so the highest set bit sets the final value.
    always_comb begin
        level_d = '0;
        for (int j = 0; j < SOFT_W; j++) begin
            if (soft_bits[j]) level_d = LVL_W'(j + 1);
        end
    end

    // Output register, one cycle behind the pending word.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level_d;
    end

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_bits == '0) |=> (level == '0));

    // R7
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_bits[SOFT_W-1] |=> (level == LVL_W'(SOFT_W)));

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(soft_bits) && $past(rst_n)) |=> $stable(level));

endmodule

// File: rtl/cpu_softirq_bank.sv
// Top of the per-processor soft interrupt bank. Decodes the bus, spreads
// hardware level updates, holds one pending word per processor and
// registers each processor's highest soft level.
// Assumes the hardware levels stay below SOFT_LO.
module cpu_softirq_bank #(
    parameter int unsigned NUM_CPU  = 16,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PAGE_LSB = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SOFT_LO  = 17,
    localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned SOFT_W  = DATA_W - SOFT_LO,
    localparam int unsigned LVL_W   = $clog2(SOFT_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     hw_valid,
    input  logic                     hw_on,
    input  logic [CPU_W-1:0]         hw_cpu,
    input  logic [LVL_W-1:0]         hw_level,
    output logic [NUM_CPU*LVL_W-1:0] soft_level
);

    logic [NUM_CPU-1:0] set_sel;
    logic [NUM_CPU-1:0] clr_sel;
    logic [NUM_CPU-1:0] rd_sel;
    logic [DATA_W-1:0]  pend_arr [NUM_CPU];
    logic [DATA_W-1:0]  hw_bit;

    sirq_addr_decode #(
        .NUM_CPU  (NUM_CPU),
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .set_sel  (set_sel),
        .clr_sel  (clr_sel),
        .rd_sel   (rd_sel)
    );

    // One-hot bit for the hardware level; level 0 gives no bit.
    always_comb begin
        hw_bit = '0;
        if (hw_level != '0) hw_bit = DATA_W'(1) << hw_level;
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        logic              hw_hit;
        logic [DATA_W-1:0] hw_set_m;
        logic [DATA_W-1:0] hw_clr_m;

        assign hw_hit   = hw_valid && (hw_cpu == CPU_W'(i));
        assign hw_set_m = (hw_hit && hw_on)  ? hw_bit : '0;
        assign hw_clr_m = (hw_hit && !hw_on) ? hw_bit : '0;

        sirq_pend_reg #(
            .DATA_W  (DATA_W),
            .SOFT_LO (SOFT_LO)
        ) u_pend (
            .clk         (clk),
            .rst_n       (rst_n),
            .sw_set      (set_sel[i]),
            .sw_clr      (clr_sel[i]),
            .sw_data     (bus_wdata),
            .hw_set_mask (hw_set_m),
            .hw_clr_mask (hw_clr_m),
            .pend        (pend_arr[i])
        );

        sirq_level_enc #(
            .SOFT_W (SOFT_W),
            .LVL_W  (LVL_W)
        ) u_level (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_bits (pend_arr[i][DATA_W-1:SOFT_LO]),
            .level     (soft_level[i*LVL_W +: LVL_W])
        );

        // R11
        other_cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_sel[i] && !clr_sel[i] && !hw_hit) |=> $stable(pend_arr[i]));
    end

    // Read mux: OR of the selected processor's word; spare words read 0.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (rd_sel[i]) bus_rdata = bus_rdata | pend_arr[i];
        end
    end

    // R2
    spare_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:2] != 2'd0) |-> (bus_rdata == '0));

endmodule

// File: tb/cpu_softirq_bank_bench.sv
module cpu_softirq_bank_bench;

    localparam int NC = 16;
    localparam logic [31:0] SMASK = 32'hFFFE_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_valid = 1'b0;
    logic        hw_on = 1'b0;
    logic [3:0]  hw_cpu = '0;
    logic [3:0]  hw_level = '0;
    logic [63:0] soft_level;

    logic [31:0] model [NC];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_softirq_bank u_cpu_softirq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_valid(hw_valid),
        .hw_on(hw_on), .hw_cpu(hw_cpu), .hw_level(hw_level),
        .soft_level(soft_level)
    );

    function automatic logic [3:0] exp_level(input logic [31:0] w);
        for (int j = 31; j >= 17; j--) if (w[j]) return 4'(j - 16);
        return 4'd0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [31:0] d);
        int c = int'(a[15:12]);
        if (a[3:2] == 2'd2) model[c] = model[c] | (d & SMASK);
        if (a[3:2] == 2'd1) model[c] = model[c] & ~(d & SMASK);
    endtask

    task automatic sw_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic hw_update(input int c, input int lvl, input bit on);
        @(negedge clk);
        hw_valid = 1'b1; hw_cpu = 4'(c); hw_level = 4'(lvl); hw_on = on;
        @(negedge clk);
        hw_valid = 1'b0;
        if (lvl != 0) begin
            if (on) model[c][lvl] = 1'b1;
            else    model[c][lvl] = 1'b0;
        end
    endtask

    task automatic read_word(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Waits one falling edge so levels settle, then compares every processor.
    task automatic check_all(input string req);
        logic [31:0] d;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            read_word(16'(c << 12), d);
            check(d == model[c], req, d, model[c]);
            check(soft_level[c*4 +: 4] == exp_level(model[c]), "R7",
                  32'(soft_level[c*4 +: 4]), 32'(exp_level(model[c])));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < NC; c++) model[c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check_all("R10");

        // R1 R3 R11: set pattern per page with stray address bits and low data bits
        for (int c = 0; c < NC; c++)
            sw_write(16'((c << 12) | 16'h07F3 | 16'h0008),
                     (32'h1 << (17 + (c % 15))) | 32'h0001_FFFF);
        for (int c = 0; c < NC; c++) begin
            check(model[c] == (32'h1 << (17 + (c % 15))), "R3",
                  model[c], 32'h1 << (17 + (c % 15)));
        end
        check_all("R1");

        // R7: exhaustive top-bit sweep on processor 3
        for (int j = 17; j <= 31; j++) begin
            sw_write(16'h3004, 32'hFFFF_FFFF);
            sw_write(16'h3008, SMASK & ~((32'h1 << (j + 1)) - 1) ^ SMASK);
            @(negedge clk);
            check(soft_level[12 +: 4] == 4'(j - 16), "R7",
                  32'(soft_level[12 +: 4]), 32'(j - 16));
        end
        sw_write(16'h3004, 32'hFFFF_FFFF);
        check_all("R4");

        // R8: level follows the pending word by one edge
        sw_write(16'h5004, 32'hFFFF_FFFF);
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 16'h5008; bus_wdata = 32'h8000_0000;
        @(negedge clk); bus_wr = 1'b0; model_write(16'h5008, 32'h8000_0000);
        check(soft_level[20 +: 4] == 4'd0, "R8", 32'(soft_level[20 +: 4]), 32'd0);
        @(negedge clk);
        check(soft_level[20 +: 4] == 4'd15, "R8", 32'(soft_level[20 +: 4]), 32'd15);

        // R6: every hardware level on every processor, set then clear half
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < 16; l++) hw_update(c, l, 1'b1);
        check_all("R6");
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < 16; l += 2) hw_update(c, l, 1'b0);
        check_all("R6");

        // R4: a full-ones clear leaves hardware bits in place
        for (int c = 0; c < NC; c++) sw_write(16'(c << 12 | 4), 32'hFFFF_FFFF);
        check_all("R4");
        check(model[7] == 32'h0000_AAAA, "R4", model[7], 32'h0000_AAAA);

        // R5: spare word write has no effect; R2: non-zero words read 0
        sw_write(16'h6008, 32'h0F00_0000);
        sw_write(16'h600C, 32'hFFFF_FFFF);
        check_all("R5");
        for (int w = 1; w < 4; w++) begin
            read_word(16'(16'h6000 | (w << 2)), d);
            check(d == 32'h0, "R2", d, 32'h0);
        end

        // R9: hardware and software on the same processor in one cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h2008; bus_wdata = 32'h0010_0000;
        hw_valid = 1'b1; hw_cpu = 4'd2; hw_level = 4'd9; hw_on = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; hw_valid = 1'b0;
        model_write(16'h2008, 32'h0010_0000);
        model[2][9] = 1'b1;
        check_all("R9");

        // R10: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < NC; c++) model[c] = '0;
        check_all("R10");

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule